// File: doc/BRIEF.md
# PCI Configuration Access Decoder

This block turns byte-wide host I/O cycles into configuration accesses for the devices on PCI bus 0. A mode pin, sampled only while reset is held, picks one of two access schemes. In the latch scheme, software first writes a packed 32-bit address into four byte ports at 0x0CF8–0x0CFB, then moves data through the four-byte window at 0x0CFC–0x0CFF. In the key scheme, a key/function byte at 0x0CF8 opens a 4 KB I/O window at 0xC000–0xCFFF. Each address in that window names a device and a register, and a separate bus-number byte lives at 0x0CFA.

The device number then passes through a programmable 32-entry table that maps devices to physical slots. A forwarded access drives a one-hot slot select together with the function, the register offset, the write data and a single-cycle read or write strobe. A read takes its data from the selected slot in the same cycle. Any access that reaches no device returns all-ones.

Top module: `cfg_access_decoder`

## Requirements
- R1: After reset, every address-register field (index, device, function, bus, enable, key) reads back as zero. Every slot-table entry holds 0xFF, so no device is reachable.
- R2: In the latch scheme, a byte write to 0x0CF8+k loads byte k of the packed address. Byte 0 is the register index, byte 1 is {device[4:0], function[2:0]}, byte 2 is the bus number and bit 7 of byte 3 is the enable flag. A read of each byte port returns the same packing, and bits 6:0 of byte 3 read as zero.
- R3: In the latch scheme, an access to 0x0CFC–0x0CFF with enable set and bus 0 reaches the slot mapped for the latched device. The forwarded register offset is the latched index OR'd with port address bits 1:0, and the latched function and the write data are forwarded with it.
- R4: While the enable flag is clear, window writes produce no strobe and window reads return 0xFF.
- R5: In either scheme, a non-zero bus number blocks forwarding: no strobe is driven and reads return 0xFF.
- R6: The table is written through map_we, map_dev and map_slot, and a new entry takes effect from the next cycle. An entry of 0xFF, an entry of NSLOT or more, or an entry naming a slot whose slot_present bit is low makes the device unreachable: no strobe, and reads return 0xFF.
- R7: In the key scheme, a write to 0x0CF8 sets the function from data bits 3:1 and the key from data bits 7:4. A read of 0x0CF8 returns {key, function, 1'b0}.
- R8: In the key scheme, 0x0CFA is a read/write bus-number byte. In the window, address bits 11:8 give the device number and address bits 7:0 give the register offset, and the function comes from the key register.
- R9: In the key scheme with a zero key, the 0xC000–0xCFFF window is not claimed: no strobe is driven and reads return 0xFF.
- R10: The scheme is taken from mode_sel only while rst_n is low. A change on mode_sel after reset has no effect.
- R11: A forwarded access raises cfg_wr or cfg_rd only in the cycle its I/O strobe is high, with exactly one cfg_sel bit set. cfg_sel is all-zero when no strobe is driven, and io_rdata follows cfg_rdata in the same cycle.
- R12: A read of any port the current scheme does not claim returns 0xFF. In the key scheme this includes 0x0CF9 and 0x0CFB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 1 | Scheme select sampled during reset: 0 latch, 1 key |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 8 | Host write byte |
| io_wr | input | 1 | Host write strobe, one cycle |
| io_rd | input | 1 | Host read strobe, one cycle |
| io_rdata | output | 8 | Host read byte, combinational |
| map_we | input | 1 | Slot-table write enable |
| map_dev | input | 5 | Device number of the table entry to write |
| map_slot | input | 8 | Slot number stored; 0xFF means none |
| slot_present | input | NSLOT | A device is attached to the slot |
| cfg_sel | output | NSLOT | One-hot slot select during a strobe |
| cfg_func | output | 3 | Function number |
| cfg_reg | output | 8 | Register offset |
| cfg_wdata | output | 8 | Write data to the slot |
| cfg_wr | output | 1 | Configuration write strobe |
| cfg_rd | output | 1 | Configuration read strobe |
| cfg_rdata | input | 8 | Read data from the selected slot |

## Verification
Directed sequences program the table with a mapped, present slot, a mapped but absent slot and an entry at NSLOT or above. These show that each reason for a miss yields 0xFF with no strobe, while a hit gives the modelled slot data on the right select line. Randomized passes in each scheme mix random devices, functions, indexes, port offsets, enable states, keys and non-zero bus numbers against a random table. They separate the offset OR with port bits 1:0, the bus and enable gating, and the key gating. Toggling mode_sel without a reset and reading back a value whose meaning differs by scheme shows that the scheme is frozen at reset.

// File: rtl/cfgd_pkg.sv
// Shared constants and types for the configuration access decoder.
// Assumes a 16-bit I/O address space and byte-wide host cycles.
package cfgd_pkg;
    localparam int DEV_W = 5;
    localparam int NDEV  = 1 << DEV_W;

    localparam logic [15:0] PORT_B0 = 16'h0CF8;
    localparam logic [15:0] PORT_B1 = 16'h0CF9;
    localparam logic [15:0] PORT_B2 = 16'h0CFA;
    localparam logic [15:0] PORT_B3 = 16'h0CFB;
    localparam logic [13:0] DATA_WIN_DW = 14'h033F;   // 0x0CFC >> 2
    localparam logic [3:0]  KEY_WIN_PAGE = 4'hC;      // 0xC000..0xCFFF

    localparam logic [7:0] NO_SLOT   = 8'hFF;
    localparam logic [7:0] MISS_DATA = 8'hFF;

    typedef enum logic {
        SCHEME_LATCH = 1'b0,
        SCHEME_KEY   = 1'b1
    } scheme_e;
endpackage

// File: rtl/cfgd_addr_regs.sv
// Address-side registers: scheme select, packed address latch fields,
// key, function and bus. Also decodes reads of these ports.
// Assumes io_wr and io_rd are single-cycle and never high together.
module cfgd_addr_regs
    import cfgd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_sel,
    input  logic [15:0]      io_addr,
    input  logic [7:0]       io_wdata,
    input  logic             io_wr,
    output scheme_e          scheme,
    output logic [7:0]       idx_q,
    output logic [DEV_W-1:0] dev_q,
    output logic [2:0]       func_q,
    output logic [7:0]       bus_q,
    output logic             en_q,
    output logic [3:0]       key_q,
    output logic             reg_hit,
    output logic [7:0]       reg_rdata
);

    // Register updates: scheme frozen at reset, fields loaded by port writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scheme <= scheme_e'(mode_sel);
            idx_q  <= '0;
            dev_q  <= '0;
            func_q <= '0;
            bus_q  <= '0;
            en_q   <= 1'b0;
            key_q  <= '0;
        end else if (io_wr) begin
            if (scheme == SCHEME_LATCH) begin
                case (io_addr)
                    PORT_B0: idx_q <= io_wdata;
                    PORT_B1: begin
                        dev_q  <= io_wdata[7:3];
                        func_q <= io_wdata[2:0];
                    end
                    PORT_B2: bus_q <= io_wdata;
                    PORT_B3: en_q  <= io_wdata[7];
                    default: ;
                endcase
            end else begin
                case (io_addr)
                    PORT_B0: begin
                        func_q <= io_wdata[3:1];
                        key_q  <= io_wdata[7:4];
                    end
                    PORT_B2: bus_q <= io_wdata;
                    default: ;
                endcase
            end
        end
    end

    // Read-back decode of the address-side ports for the active scheme.
    always_comb begin
        reg_hit   = 1'b0;
        reg_rdata = MISS_DATA;
        if (scheme == SCHEME_LATCH) begin
            case (io_addr)
                PORT_B0: begin reg_hit = 1'b1; reg_rdata = idx_q;            end
                PORT_B1: begin reg_hit = 1'b1; reg_rdata = {dev_q, func_q};  end
                PORT_B2: begin reg_hit = 1'b1; reg_rdata = bus_q;            end
                PORT_B3: begin reg_hit = 1'b1; reg_rdata = {en_q, 7'b0};     end
                default: ;
            endcase
        end else begin
            case (io_addr)
                PORT_B0: begin reg_hit = 1'b1; reg_rdata = {key_q, func_q, 1'b0}; end
                PORT_B2: begin reg_hit = 1'b1; reg_rdata = bus_q;                 end
                default: ;
            endcase
        end
    end

    AST_SCHEME_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(scheme));                                                     // R10
    AST_KEY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (scheme == SCHEME_KEY && io_wr && io_addr == PORT_B0)
        |=> (key_q == $past(io_wdata[7:4]) && func_q == $past(io_wdata[3:1]))); // R7

endmodule

// File: rtl/cfgd_window.sv
// Window decode: works out whether the host address falls in the data
// window of the active scheme, whether forwarding is allowed, and the
// device number and register offset to present. Purely combinational.
module cfgd_window
    import cfgd_pkg::*;
(
    input  scheme_e          scheme,
    input  logic [15:0]      io_addr,
    input  logic [7:0]       idx_q,
    input  logic [DEV_W-1:0] dev_q,
    input  logic [7:0]       bus_q,
    input  logic             en_q,
    input  logic [3:0]       key_q,
    output logic             win_hit,
    output logic             win_fwd,
    output logic [DEV_W-1:0] win_dev,
    output logic [7:0]       win_reg
);

    // Per-scheme selection of window, gating, device and offset.
    always_comb begin
        if (scheme == SCHEME_LATCH) begin
            win_hit = (io_addr[15:2] == DATA_WIN_DW);
            win_fwd = en_q && (bus_q == 8'd0);
            win_dev = dev_q;
            win_reg = {idx_q[7:2], idx_q[1:0] | io_addr[1:0]};
        end else begin
            win_hit = (io_addr[15:12] == KEY_WIN_PAGE) && (key_q != 4'd0);
            win_fwd = (bus_q == 8'd0);
            win_dev = {1'b0, io_addr[11:8]};
            win_reg = io_addr[7:0];
        end
    end

endmodule

// File: rtl/cfgd_slot_map.sv
// Device-to-slot table. One 8-bit entry per device number, reset to
// 0xFF (no slot). Lookup is combinational; writes land on the next edge.
module cfgd_slot_map
    import cfgd_pkg::*;
#(
    parameter int NSLOT  = 8,
    parameter int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_we,
    input  logic [DEV_W-1:0]  map_dev,
    input  logic [7:0]        map_slot,
    input  logic [DEV_W-1:0]  look_dev,
    output logic              slot_ok,
    output logic [SLOT_W-1:0] slot_idx
);

    logic [7:0] tbl [NDEV];
    logic [7:0] entry;

    // Table storage: reset to no-slot, single entry written per cycle.
    always_ff @(posedge clk) begin
        for (int d = 0; d < NDEV; d++) begin
            if (!rst_n)
                tbl[d] <= NO_SLOT;
            else if (map_we && map_dev == DEV_W'(d))
                tbl[d] <= map_slot;
        end
    end

    // Lookup: an entry is usable only if it names an existing slot.
    always_comb begin
        entry    = tbl[look_dev];
        slot_ok  = (entry != NO_SLOT) && (32'(entry) < NSLOT);
        slot_idx = entry[SLOT_W-1:0];
    end

    AST_MAP_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        map_we |=> (tbl[$past(map_dev)] == $past(map_slot)));                 // R6

endmodule

// File: rtl/cfg_access_decoder.sv
// Top of the configuration access decoder. Combines the address
// registers, window decode and slot table, then drives the slot bus.
// Assumes host strobes last one cycle and slots answer combinationally.
module cfg_access_decoder
    import cfgd_pkg::*;
#(
    parameter int NSLOT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_sel,
    input  logic [15:0]      io_addr,
    input  logic [7:0]       io_wdata,
    input  logic             io_wr,
    input  logic             io_rd,
    output logic [7:0]       io_rdata,
    input  logic             map_we,
    input  logic [4:0]       map_dev,
    input  logic [7:0]       map_slot,
    input  logic [NSLOT-1:0] slot_present,
    output logic [NSLOT-1:0] cfg_sel,
    output logic [2:0]       cfg_func,
    output logic [7:0]       cfg_reg,
    output logic [7:0]       cfg_wdata,
    output logic             cfg_wr,
    output logic             cfg_rd,
    input  logic [7:0]       cfg_rdata
);

    localparam int SLOT_W    = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam int SLOT_SPAN = 1 << SLOT_W;

    scheme_e          scheme;
    logic [7:0]       idx_q, bus_q, reg_rdata, win_reg;
    logic [DEV_W-1:0] dev_q, win_dev;
    logic [2:0]       func_q;
    logic [3:0]       key_q;
    logic             en_q, reg_hit, win_hit, win_fwd, slot_ok;
    logic [SLOT_W-1:0] slot_idx;
    logic [SLOT_SPAN-1:0] pres_ext;
    logic             tgt_hit, strobe;

    cfgd_addr_regs u_regs (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr),
        .scheme(scheme), .idx_q(idx_q), .dev_q(dev_q), .func_q(func_q),
        .bus_q(bus_q), .en_q(en_q), .key_q(key_q),
        .reg_hit(reg_hit), .reg_rdata(reg_rdata)
    );

    cfgd_window u_win (
        .scheme(scheme), .io_addr(io_addr), .idx_q(idx_q), .dev_q(dev_q),
        .bus_q(bus_q), .en_q(en_q), .key_q(key_q),
        .win_hit(win_hit), .win_fwd(win_fwd), .win_dev(win_dev), .win_reg(win_reg)
    );

    cfgd_slot_map #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_map (
        .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_dev(map_dev),
        .map_slot(map_slot), .look_dev(win_dev),
        .slot_ok(slot_ok), .slot_idx(slot_idx)
    );

    // Target qualification: window, gating, mapping and presence.
    always_comb begin
        pres_ext = SLOT_SPAN'(slot_present);
        tgt_hit  = win_hit && win_fwd && slot_ok && pres_ext[slot_idx];
        cfg_wr   = io_wr && tgt_hit;
        cfg_rd   = io_rd && tgt_hit;
        strobe   = cfg_wr || cfg_rd;
    end

    // One select line per slot, raised only with a strobe.
    for (genvar g = 0; g < NSLOT; g++) begin : g_sel
        assign cfg_sel[g] = strobe && (slot_idx == SLOT_W'(g));
    end

    assign cfg_func  = func_q;
    assign cfg_reg   = win_reg;
    assign cfg_wdata = io_wdata;

    // Host read data: own registers, else slot data, else all-ones.
    always_comb begin
        if (reg_hit)      io_rdata = reg_rdata;
        else if (tgt_hit) io_rdata = cfg_rdata;
        else              io_rdata = MISS_DATA;
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr || cfg_rd) |-> ($countones(cfg_sel) == 1));                   // R11
    AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr || cfg_rd) |-> (cfg_sel == '0));                             // R11
    AST_BUS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_q != 8'd0) |-> !(cfg_wr || cfg_rd));                             // R5
    AST_EN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (scheme == SCHEME_LATCH && !en_q) |-> !(cfg_wr || cfg_rd));           // R4
    AST_KEY_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        (scheme == SCHEME_KEY && key_q == 4'd0) |-> !(cfg_wr || cfg_rd));     // R9
    AST_MISS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && win_hit && !cfg_rd) |-> (io_rdata == MISS_DATA));           // R6

endmodule

// File: tb/test_cfg_access_decoder.sv
module test_cfg_access_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NSLOT = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_sel = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic map_we = 1'b0;
    logic [4:0] map_dev = '0;
    logic [7:0] map_slot = '0;
    logic [NSLOT-1:0] slot_present = 8'b1111_1011;
    logic [NSLOT-1:0] cfg_sel;
    logic [2:0] cfg_func;
    logic [7:0] cfg_reg, cfg_wdata, cfg_rdata;
    logic cfg_wr, cfg_rd;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] tbl_m [32];

    logic [7:0] s_rd, s_reg, s_wd;
    logic [2:0] s_func;
    logic [NSLOT-1:0] s_sel;
    logic s_stb, s_other, s_after;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_access_decoder #(.NSLOT(NSLOT)) i_cfg_access_decoder (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd),
        .io_rdata(io_rdata), .map_we(map_we), .map_dev(map_dev),
        .map_slot(map_slot), .slot_present(slot_present), .cfg_sel(cfg_sel),
        .cfg_func(cfg_func), .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata)
    );

    function automatic logic [7:0] slot_val(int s, logic [2:0] f, logic [7:0] r);
        return 8'(int'(r) + s * 37 + int'(f) * 5 + 17);
    endfunction

    function automatic bit dev_ok(int d);
        logic [7:0] e = tbl_m[d];
        return (e < 8'(NSLOT)) && slot_present[e[2:0]];
    endfunction

    // Slot model: answers with a value derived from slot, function and offset.
    always_comb begin
        cfg_rdata = 8'h00;
        for (int k = 0; k < NSLOT; k++)
            if (cfg_sel[k]) cfg_rdata = slot_val(k, cfg_func, cfg_reg);
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(bit m);
        @(negedge clk);
        mode_sel = m; rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int d = 0; d < 32; d++) tbl_m[d] = 8'hFF;
    endtask

    task automatic map_wr(int d, logic [7:0] s);
        @(negedge clk);
        map_we = 1'b1; map_dev = 5'(d); map_slot = s;
        @(negedge clk);
        map_we = 1'b0;
        tbl_m[d] = s;
    endtask

    task automatic acc(bit wr, logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = wr; io_rd = !wr;
        #1;
        s_rd = io_rdata; s_sel = cfg_sel; s_reg = cfg_reg; s_func = cfg_func; s_wd = cfg_wdata;
        s_stb = wr ? cfg_wr : cfg_rd; s_other = wr ? cfg_rd : cfg_wr;
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
        #1;
        s_after = cfg_wr | cfg_rd | (|cfg_sel);
    endtask

    // Check an access outcome: hit or miss, select, offset, data.
    task automatic chk_acc(string req, bit wr, bit hit, int slot, logic [2:0] f, logic [7:0] r, logic [7:0] d);
        chk({req, " strobe"}, s_stb, hit);
        chk({req, " no-cross-strobe"}, s_other, 0);
        chk({req, " strobe-one-cycle R11"}, s_after, 0);
        if (hit) begin
            chk({req, " sel"}, s_sel, 32'(1) << slot);
            chk({req, " reg"}, s_reg, r);
            chk({req, " func"}, s_func, f);
            if (wr) chk({req, " wdata"}, s_wd, d);
            else    chk({req, " rdata"}, s_rd, slot_val(slot, f, r));
        end else begin
            chk({req, " sel-idle"}, s_sel, 0);
            if (!wr) chk({req, " rdata-miss"}, s_rd, 8'hFF);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R11 actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));

        // ---------------- latch scheme ----------------
        do_reset(1'b0);
        for (int p = 0; p < 4; p++) begin
            acc(1'b0, 16'h0CF8 + 16'(p), 8'h00);
            chk("R1 latch byte reset", s_rd, 8'h00);
        end
        acc(1'b1, 16'h0CFB, 8'h80);                 // enable, dev 0
        acc(1'b0, 16'h0CFC, 8'h00);
        chk_acc("R1 table reset", 1'b0, 1'b0, 0, 3'd0, 8'd0, 8'd0);

        map_wr(3, 8'd5);
        map_wr(7, 8'd2);                            // slot 2 absent
        map_wr(9, 8'd10);                           // beyond NSLOT
        acc(1'b1, 16'h0CF8, 8'h44);
        acc(1'b1, 16'h0CF9, 8'h1E);                 // dev 3, func 6
        acc(1'b1, 16'h0CFA, 8'h00);
        acc(1'b1, 16'h0CFB, 8'hFF);
        acc(1'b0, 16'h0CF8, 8'h00); chk("R2 byte0", s_rd, 8'h44);
        acc(1'b0, 16'h0CF9, 8'h00); chk("R2 byte1", s_rd, 8'h1E);
        acc(1'b0, 16'h0CFB, 8'h00); chk("R2 byte3", s_rd, 8'h80);

        acc(1'b0, 16'h0CFE, 8'h00);
        chk_acc("R3 read", 1'b0, 1'b1, 5, 3'd6, 8'h46, 8'h00);
        acc(1'b1, 16'h0CFD, 8'hA5);
        chk_acc("R3 write", 1'b1, 1'b1, 5, 3'd6, 8'h45, 8'hA5);

        acc(1'b1, 16'h0CFB, 8'h7F);                 // enable clear
        acc(1'b0, 16'h0CFC, 8'h00);
        chk_acc("R4 read", 1'b0, 1'b0, 0, 3'd0, 8'd0, 8'd0);
        acc(1'b1, 16'h0CFC, 8'h12);
        chk_acc("R4 write", 1'b1, 1'b0, 0, 3'd0, 8'd0, 8'd0);

        acc(1'b1, 16'h0CFB, 8'h80);
        acc(1'b1, 16'h0CFA, 8'h01);
        acc(1'b0, 16'h0CFF, 8'h00);
        chk_acc("R5 latch bus1", 1'b0, 1'b0, 0, 3'd0, 8'd0, 8'd0);
        acc(1'b1, 16'h0CFA, 8'h00);

        acc(1'b1, 16'h0CF9, 8'h38);                 // dev 7 (slot absent)
        acc(1'b0, 16'h0CFC, 8'h00);
        chk_acc("R6 absent slot", 1'b0, 1'b0, 0, 3'd0, 8'd0, 8'd0);
        acc(1'b1, 16'h0CF9, 8'h48);                 // dev 9 (slot >= NSLOT)
        acc(1'b0, 16'h0CFC, 8'h00);
        chk_acc("R6 slot out of range", 1'b0, 1'b0, 0, 3'd0, 8'd0, 8'd0);

        mode_sel = 1'b1;                            // no reset
        acc(1'b1, 16'h0CF8, 8'h13);
        acc(1'b0, 16'h0CF8, 8'h00);
        chk("R10 scheme frozen", s_rd, 8'h13);
        mode_sel = 1'b0;

        for (int d = 0; d < 32; d++) begin
            int r = $urandom % 14;
            map_wr(d, (r < 12) ? 8'(r) : 8'hFF);
        end
        for (int it = 0; it < 250; it++) begin
            logic [7:0] idx = 8'($urandom);
            logic [2:0] f   = 3'($urandom);
            int dv          = $urandom % 32;
            logic [7:0] bus = ($urandom % 4 == 0) ? 8'($urandom % 255 + 1) : 8'h00;
            bit en          = ($urandom % 5 != 0);
            logic [1:0] off = 2'($urandom);
            bit hit;
            acc(1'b1, 16'h0CF8, idx);
            acc(1'b1, 16'h0CF9, {5'(dv), f});
            acc(1'b1, 16'h0CFA, bus);
            acc(1'b1, 16'h0CFB, {en, 7'($urandom)});
            hit = en && (bus == 0) && dev_ok(dv);
            acc(1'b0, 16'h0CFC + 16'(off), 8'h00);
            chk_acc("R3 R4 R5 R6 random latch", 1'b0, hit, int'(tbl_m[dv]), f,
                    {idx[7:2], idx[1:0] | off}, 8'h00);
        end

        // ---------------- key scheme ----------------
        do_reset(1'b1);
        acc(1'b0, 16'h0CF8, 8'h00); chk("R1 key reset", s_rd, 8'h00);
        acc(1'b0, 16'h0CFA, 8'h00); chk("R1 bus reset", s_rd, 8'h00);
        acc(1'b0, 16'h0CF9, 8'h00); chk("R12 key scheme 0CF9", s_rd, 8'hFF);
        acc(1'b0, 16'h0CFB, 8'h00); chk("R12 key scheme 0CFB", s_rd, 8'hFF);
        acc(1'b0, 16'h0080, 8'h00); chk("R12 stray port", s_rd, 8'hFF);

        acc(1'b1, 16'h0CF8, 8'hA7);
        acc(1'b0, 16'h0CF8, 8'h00); chk("R7 key readback", s_rd, 8'hA6);
        map_wr(4, 8'd1);
        acc(1'b1, 16'h0CFA, 8'h05);
        acc(1'b0, 16'h0CFA, 8'h00); chk("R8 bus readback", s_rd, 8'h05);
        acc(1'b0, 16'hC43C, 8'h00);
        chk_acc("R5 key bus5", 1'b0, 1'b0, 0, 3'd0, 8'd0, 8'd0);
        acc(1'b1, 16'h0CFA, 8'h00);
        acc(1'b0, 16'hC43C, 8'h00);
        chk_acc("R8 read", 1'b0, 1'b1, 1, 3'd3, 8'h3C, 8'h00);
        acc(1'b1, 16'hC410, 8'h5A);
        chk_acc("R8 write", 1'b1, 1'b1, 1, 3'd3, 8'h10, 8'h5A);

        acc(1'b1, 16'h0CF8, 8'h06);                 // key 0, func 3
        acc(1'b0, 16'h0CF8, 8'h00); chk("R7 zero key readback", s_rd, 8'h06);
        acc(1'b0, 16'hC43C, 8'h00);
        chk_acc("R9 closed read", 1'b0, 1'b0, 0, 3'd0, 8'd0, 8'd0);
        acc(1'b1, 16'hC43C, 8'h77);
        chk_acc("R9 closed write", 1'b1, 1'b0, 0, 3'd0, 8'd0, 8'd0);

        for (int d = 0; d < 16; d++) begin
            int r = $urandom % 12;
            map_wr(d, (r < 10) ? 8'(r) : 8'hFF);
        end
        for (int it = 0; it < 250; it++) begin
            logic [3:0] key = ($urandom % 5 == 0) ? 4'h0 : 4'($urandom % 15 + 1);
            logic [2:0] f   = 3'($urandom);
            logic [7:0] bus = ($urandom % 4 == 0) ? 8'($urandom % 255 + 1) : 8'h00;
            int dv          = $urandom % 16;
            logic [7:0] rg  = 8'($urandom);
            bit hit;
            acc(1'b1, 16'h0CF8, {key, f, 1'($urandom)});
            acc(1'b1, 16'h0CFA, bus);
            hit = (key != 0) && (bus == 0) && dev_ok(dv);
            acc(1'b0, {4'hC, 4'(dv), rg}, 8'h00);
            chk_acc("R8 R9 R5 random key", 1'b0, hit, int'(tbl_m[dv]), f, rg, 8'h00);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule